// File: doc/BRIEF.md
# Transmit Descriptor Engine with Address-Table Loading

This block moves outgoing Ethernet frames from host memory to a MAC byte stream. Software builds a ring of four-longword descriptors in memory, sets the run bit, and writes the poll register. The engine then reads the descriptor at its current position. If the descriptor is owned by the engine, it fetches the buffer one longword at a time, sends the bytes on a valid/ready byte stream, and writes a completion status back into the descriptor. It keeps walking the ring until it reaches a descriptor it does not own.

One descriptor flag changes the job. When the flag is set, the buffer holds a 192-byte address-table image instead of a frame. The engine loads that image into a table of sixteen 48-bit destination addresses. It sends nothing on the wire and writes a distinctive status value when the load finishes. The receive side presents a destination address and gets back a single match flag.

Software drives the block through a three-register write port: ring base, poll, and run control. Memory is reached through a single-outstanding 32-bit request/acknowledge master.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `mem_req` and `tx_valid` are low, and `flt_match` is low for every address.
- R2: Register offset 2 bit 0 is the run bit. A write with bit 0 set to the poll register (offset 1) has no effect while run is clear. Setting run moves the current descriptor to the ring base, which is written at offset 0.
- R3: On a poll, the engine reads the status longword (descriptor offset 0). If bit 31 (ownership) is clear, it makes no further memory access until the next poll.
- R4: For an owned descriptor, the control longword is at offset +4 and the word-aligned buffer address is at +8. The byte count is in control bits 10:0. The engine sends exactly that many bytes in memory order, taking each longword least significant byte first.
- R5: `tx_last` is high with the final byte of a descriptor only when control bit 30 is set. It is low for every other byte.
- R6: After a frame is sent, the engine writes 0x00000000 to the status longword, so bit 31 is clear. It then moves to the descriptor 16 bytes further on.
- R7: When control bit 25 is set, the descriptor that follows is the one at the ring base.
- R8: When control bit 27 is set and the count is 192, the engine reads 48 longwords and sends no byte. It then writes 0x7FFFFFFF to the status longword.
- R9: Table entry k is built from the low 16 bits of buffer longwords 3k, 3k+1 and 3k+2, and the first of these holds address bytes 0 and 1. `flt_addr` carries address byte i at bits 8i+7:8i. `flt_match` is high exactly when `flt_addr` equals a loaded entry. No entry matches before the first load.
- R10: An error occurs for a frame descriptor with a count of 0, or for a table descriptor whose count is not 192. On an error the engine writes status 0x00008000 and sends no byte, and the address table is left unchanged.
- R11: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low. Stalls on either side do not change the byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 ring base, 1 poll, 2 run control |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address of the longword |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte to transmit |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_ready | input | 1 | MAC accepts the byte |
| flt_addr | input | 48 | Destination address to look up |
| flt_match | output | 1 | Address equals a loaded table entry |

## Verification
The bench builds the block with its default parameters: sixteen table entries, which gives the 192-byte table image, and 32-bit addresses. It places a four-descriptor ring with the wrap flag on the final slot, so repeated rounds cross the ring boundary and reach the wrap path. A memory model with random latency of zero to two cycles, together with a throttled `tx_ready`, reaches the hold-while-stalled rules. Both a correct table image and wrongly sized table images are sent, so the 0x7FFFFFFF and 0x00008000 write-backs and the unchanged table can all be observed through `flt_match`.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    // Descriptor bit positions (behavioural: software and engine agree on them)
    localparam int OWN_BIT   = 31;
    localparam int LAST_BIT  = 30;
    localparam int SETUP_BIT = 27;
    localparam int EOR_BIT   = 25;
    localparam int LEN_W     = 11;
    localparam int DESC_BYTES = 16;
    localparam int ENTRY_BYTES = 12;

    // Completion words written back to the status longword
    localparam logic [31:0] ST_FRAME_OK = 32'h0000_0000;
    localparam logic [31:0] ST_TABLE_OK = 32'h7FFF_FFFF;
    localparam logic [31:0] ST_FAULT    = 32'h0000_8000;

    // Register map
    localparam logic [1:0] RA_BASE = 2'd0;
    localparam logic [1:0] RA_POLL = 2'd1;
    localparam logic [1:0] RA_RUN  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STS,
        S_RD_CTL,
        S_RD_BUF,
        S_RD_DATA,
        S_SEND,
        S_RD_TABLE,
        S_WR_STS
    } eng_state_t;

    typedef struct packed {
        logic             last;
        logic             table_load;
        logic             wrap;
        logic [LEN_W-1:0] len;
    } desc_ctl_t;

    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[8*lane +: 8];
    endfunction
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
    import tdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          poll_take,
    output logic [AW-1:0] ring_base,
    output logic          run,
    output logic          start_pulse,
    output logic          poll_pending
);
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_base    <= '0;
            run          <= 1'b0;
            start_pulse  <= 1'b0;
            poll_pending <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (poll_take) poll_pending <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    RA_BASE: ring_base <= reg_wdata[AW-1:0];
                    RA_POLL: if (reg_wdata[0] && run) poll_pending <= 1'b1;
                    RA_RUN: begin
                        run <= reg_wdata[0];
                        if (reg_wdata[0] && !run) start_pulse <= 1'b1;
                        if (!reg_wdata[0]) poll_pending <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a poll while stopped leaves nothing pending
    p_poll_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_POLL && !run) |=> !poll_pending);
endmodule

// File: rtl/tdma_filter.sv
module tdma_filter #(
    parameter  int N_ENT = 16,
    localparam int EW    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [EW-1:0] ld_entry,
    input  logic [1:0]    ld_part,
    input  logic [15:0]   ld_half,
    input  logic [47:0]   flt_addr,
    output logic          flt_match
);
    logic [47:0]      tbl [N_ENT];
    logic [N_ENT-1:0] vld;
    logic [N_ENT-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (ld_en) begin
            case (ld_part)
                2'd0: tbl[ld_entry][15:0]  <= ld_half;
                2'd1: tbl[ld_entry][31:16] <= ld_half;
                2'd2: begin
                    tbl[ld_entry][47:32] <= ld_half;
                    vld[ld_entry]        <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tbl[i] == flt_addr);
    end

    assign flt_match = |hit;

    // R9: each entry is loaded in exactly three halves
    p_ld_part_r9: assert property (@(posedge clk) disable iff (rst)
        ld_en |-> (ld_part != 2'd3));
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
    import tdma_pkg::*;
#(
    parameter  int AW    = 32,
    parameter  int N_ENT = 16,
    localparam int EW    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          start_pulse,
    input  logic          poll_pending,
    input  logic [AW-1:0] ring_base,
    output logic          poll_take,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          ld_en,
    output logic [EW-1:0] ld_entry,
    output logic [1:0]    ld_part,
    output logic [15:0]   ld_half
);
    localparam logic [LEN_W-1:0] TABLE_LEN = LEN_W'(N_ENT * ENTRY_BYTES);
    localparam logic [AW-1:0]    STRIDE    = AW'(DESC_BYTES);
    localparam logic [EW-1:0]    LAST_ENT  = EW'(N_ENT - 1);

    eng_state_t        state;
    logic [AW-1:0]     cur;
    logic [AW-1:0]     rd_ptr;
    desc_ctl_t         ctl;
    logic [31:0]       word_buf;
    logic [LEN_W-1:0]  bytes_left;
    logic [1:0]        lane;
    logic [31:0]       stat_r;
    logic [EW-1:0]     ent;
    logic [1:0]        part;

    assign poll_take = (state == S_IDLE) && run && poll_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cur        <= '0;
            rd_ptr     <= '0;
            ctl        <= '0;
            word_buf   <= '0;
            bytes_left <= '0;
            lane       <= '0;
            stat_r     <= '0;
            ent        <= '0;
            part       <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start_pulse) cur <= ring_base;
                    if (poll_take) state <= S_RD_STS;
                end
                S_RD_STS: if (mem_ack) begin
                    state <= mem_rdata[OWN_BIT] ? S_RD_CTL : S_IDLE;
                end
                S_RD_CTL: if (mem_ack) begin
                    ctl <= '{last:       mem_rdata[LAST_BIT],
                             table_load: mem_rdata[SETUP_BIT],
                             wrap:       mem_rdata[EOR_BIT],
                             len:        mem_rdata[LEN_W-1:0]};
                    state <= S_RD_BUF;
                end
                S_RD_BUF: if (mem_ack) begin
                    rd_ptr     <= {mem_rdata[AW-1:2], 2'b00};
                    ent        <= '0;
                    part       <= '0;
                    lane       <= '0;
                    bytes_left <= ctl.len;
                    if (ctl.table_load) begin
                        if (ctl.len == TABLE_LEN) begin
                            state <= S_RD_TABLE;
                        end else begin
                            stat_r <= ST_FAULT;
                            state  <= S_WR_STS;
                        end
                    end else if (ctl.len == '0) begin
                        stat_r <= ST_FAULT;
                        state  <= S_WR_STS;
                    end else begin
                        state <= S_RD_DATA;
                    end
                end
                S_RD_DATA: if (mem_ack) begin
                    word_buf <= mem_rdata;
                    rd_ptr   <= rd_ptr + AW'(4);
                    state    <= S_SEND;
                end
                S_SEND: if (tx_ready) begin
                    bytes_left <= bytes_left - LEN_W'(1);
                    lane       <= lane + 2'd1;
                    if (bytes_left == LEN_W'(1)) begin
                        stat_r <= ST_FRAME_OK;
                        state  <= S_WR_STS;
                    end else if (lane == 2'd3) begin
                        state <= S_RD_DATA;
                    end
                end
                S_RD_TABLE: if (mem_ack) begin
                    rd_ptr <= rd_ptr + AW'(4);
                    if (part == 2'd2) begin
                        part <= 2'd0;
                        ent  <= ent + EW'(1);
                        if (ent == LAST_ENT) begin
                            stat_r <= ST_TABLE_OK;
                            state  <= S_WR_STS;
                        end
                    end else begin
                        part <= part + 2'd1;
                    end
                end
                S_WR_STS: if (mem_ack) begin
                    cur   <= ctl.wrap ? ring_base : cur + STRIDE;
                    state <= S_RD_STS;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = stat_r;
        case (state)
            S_RD_STS:   mem_req = 1'b1;
            S_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'(4);
            end
            S_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'(8);
            end
            S_RD_DATA, S_RD_TABLE: begin
                mem_req  = 1'b1;
                mem_addr = rd_ptr;
            end
            S_WR_STS: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_valid = (state == S_SEND);
    assign tx_data  = lane_byte(word_buf, lane);
    assign tx_last  = (state == S_SEND) && ctl.last && (bytes_left == LEN_W'(1));

    assign ld_en    = (state == S_RD_TABLE) && mem_ack;
    assign ld_entry = ent;
    assign ld_part  = part;
    assign ld_half  = mem_rdata[15:0];

    // R11: memory request held until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: byte held while the MAC stalls
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R6: every write-back releases ownership
    p_own_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R3: an unowned descriptor ends the scan
    p_unowned_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD_STS && mem_ack && !mem_rdata[OWN_BIT]) |=> !mem_req);

    // R7: wrap flag sends the next status read to the ring base
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_WR_STS && mem_ack && ctl.wrap) |=> (mem_req && mem_addr == ring_base));
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import tdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int N_ENT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic [47:0]   flt_addr,
    output logic          flt_match
);
    localparam int EW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    logic [AW-1:0] ring_base;
    logic          run;
    logic          start_pulse;
    logic          poll_pending;
    logic          poll_take;
    logic          ld_en;
    logic [EW-1:0] ld_entry;
    logic [1:0]    ld_part;
    logic [15:0]   ld_half;

    tdma_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .poll_take    (poll_take),
        .ring_base    (ring_base),
        .run          (run),
        .start_pulse  (start_pulse),
        .poll_pending (poll_pending)
    );

    tdma_engine #(.AW(AW), .N_ENT(N_ENT)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .start_pulse  (start_pulse),
        .poll_pending (poll_pending),
        .ring_base    (ring_base),
        .poll_take    (poll_take),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .ld_en        (ld_en),
        .ld_entry     (ld_entry),
        .ld_part      (ld_part),
        .ld_half      (ld_half)
    );

    tdma_filter #(.N_ENT(N_ENT)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_entry  (ld_entry),
        .ld_part   (ld_part),
        .ld_half   (ld_half),
        .flt_addr  (flt_addr),
        .flt_match (flt_match)
    );
endmodule

// File: tb/tb_txdesc_dma.sv
module tb_txdesc_dma;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam int RING       = 32'h100;
    localparam int NDESC      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [47:0] flt_addr = 48'd0;
    logic        flt_match;

    logic [31:0] mem [MEM_WORDS];
    int n_reads = 0, n_sts_reads = 0;
    logic [31:0] last_sts_addr = 32'd0;
    int lat_cnt = 0, max_lat = 0, ready_pct = 100;
    int tests = 0, fails = 0;
    int cur_idx = 0;
    byte unsigned got_b[$], exp_b[$];
    bit got_l[$], exp_l[$];
    logic [47:0] tbl_exp [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_dma dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .flt_addr(flt_addr), .flt_match(flt_match)
    );

    // memory model: one-cycle ack after a random wait
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat_cnt > 0) begin
                lat_cnt--;
            end else begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    n_reads++;
                    if (mem_addr >= RING && mem_addr < RING + 16*NDESC && mem_addr[3:0] == 4'd0) begin
                        n_sts_reads++;
                        last_sts_addr = mem_addr;
                    end
                end
                lat_cnt = $urandom_range(0, max_lat);
            end
        end
    end

    // MAC model: throttled ready, byte capture
    always @(negedge clk) begin
        tx_ready = ($urandom_range(0, 99) < ready_pct);
        if (tx_valid && tx_ready) begin
            got_b.push_back(tx_data);
            got_l.push_back(tx_last);
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 40) begin
            @(negedge clk);
            if (mem_req || tx_valid) q = 0; else q++;
        end
    endtask

    task automatic probe(input logic [47:0] a, input logic expv, input string req, input string what);
        @(negedge clk);
        flt_addr = a;
        #1;
        check(req, flt_match, expv, what);
    endtask

    function automatic logic [31:0] ctl_word(input int len, input bit ls, input bit tbl, input bit eor);
        logic [31:0] w = 32'(len) | 32'h2000_0000;
        if (ls)  w |= 32'h4000_0000;
        if (tbl) w |= 32'h0800_0000;
        if (eor) w |= 32'h0200_0000;
        return w;
    endfunction

    function automatic int dw(input int d);
        return (RING >> 2) + 4*d;
    endfunction

    task automatic set_desc(input int d, input logic [31:0] sts, input logic [31:0] ctl, input logic [31:0] ba);
        mem[dw(d)] = sts; mem[dw(d)+1] = ctl; mem[dw(d)+2] = ba; mem[dw(d)+3] = 32'd0;
    endtask

    // fill a frame buffer for slot d and record the expected stream
    task automatic add_frame(input int d, input int len, input bit ls);
        int ba = 32'h400 + 32'h80*d;
        for (int w = 0; w < 26; w++) mem[(ba>>2)+w] = $urandom;
        for (int b = 0; b < len; b++) begin
            exp_b.push_back(mem[(ba>>2)+b/4][8*(b%4) +: 8]);
            exp_l.push_back(ls && (b == len-1));
        end
        set_desc(d, 32'h8000_0000, ctl_word(len, ls, 1'b0, d == NDESC-1), ba);
    endtask

    task automatic clear_streams();
        exp_b.delete(); exp_l.delete(); got_b.delete(); got_l.delete();
    endtask

    task automatic compare_stream(input string req, input string what);
        int mism = 0, lastm = 0, n;
        check(req, got_b.size(), exp_b.size(), {what, " byte count"});
        n = (got_b.size() < exp_b.size()) ? got_b.size() : exp_b.size();
        for (int i = 0; i < n; i++) begin
            if (got_b[i] != exp_b[i]) mism++;
            if (got_l[i] != exp_l[i]) lastm++;
        end
        check(req, mism, 0, {what, " byte mismatches"});
        check("R5", lastm, 0, {what, " tx_last mismatches"});
    endtask

    task automatic run_round(input int k, input string req);
        bit wrapped = 0;
        clear_streams();
        for (int j = 0; j < k; j++) begin
            int d = (cur_idx + j) % NDESC;
            if (d == NDESC-1 && j < k) wrapped = 1;
            add_frame(d, $urandom_range(1, 100), $urandom_range(0, 1) == 1);
        end
        wr_reg(2'd1, 32'd1);
        wait_quiet();
        compare_stream(req, "round");
        for (int j = 0; j < k; j++) begin
            int d = (cur_idx + j) % NDESC;
            check("R6", mem[dw(d)], 32'h0000_0000, "frame status write-back");
        end
        check(wrapped ? "R7" : "R6", last_sts_addr, RING + 16*((cur_idx + k) % NDESC), "next descriptor address");
        cur_idx = (cur_idx + k) % NDESC;
    endtask

    initial begin
        int reads0;
        int d;
        logic [47:0] bad_ent;
        void'($urandom(32'd4242));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", mem_req, 1'b0, "mem_req after reset");
        check("R1", tx_valid, 1'b0, "tx_valid after reset");
        probe(48'd0, 1'b0, "R1", "zero address after reset");
        probe(48'h0123_4567_89AB, 1'b0, "R1", "random address after reset");

        // R2 poll ignored while stopped
        wr_reg(2'd0, RING);
        for (int i = 0; i < NDESC; i++) set_desc(i, 32'd0, 32'd0, 32'd0);
        wr_reg(2'd1, 32'd1);
        repeat (30) @(negedge clk);
        check("R2", n_reads, 0, "reads after poll while stopped");

        // R3 unowned descriptor
        wr_reg(2'd2, 32'd1);
        wr_reg(2'd1, 32'd1);
        wait_quiet();
        check("R3", n_reads, 1, "reads on unowned descriptor");
        check("R3", last_sts_addr, RING, "first status address");

        // R4/R5/R6/R7 random rounds with full speed
        for (int r = 0; r < 5; r++) begin
            max_lat = r % 3;
            run_round($urandom_range(1, 3), "R4");
        end

        // R9 nothing matches before load; build a table image
        for (int e = 0; e < 16; e++) begin
            logic [31:0] w0, w1, w2;
            w0 = $urandom; w1 = $urandom; w2 = $urandom;
            mem[(32'h800>>2) + 3*e]     = w0;
            mem[(32'h800>>2) + 3*e + 1] = w1;
            mem[(32'h800>>2) + 3*e + 2] = w2;
            tbl_exp[e] = {w2[15:0], w1[15:0], w0[15:0]};
        end
        probe(tbl_exp[3], 1'b0, "R9", "entry before first load");

        // R8 table load followed by a short frame
        clear_streams();
        d = cur_idx;
        set_desc(d, 32'h8000_0000, ctl_word(192, 1'b1, 1'b1, d == NDESC-1), 32'h800);
        add_frame((d+1) % NDESC, 8, 1'b1);
        wr_reg(2'd1, 32'd1);
        wait_quiet();
        check("R8", mem[dw(d)], 32'h7FFF_FFFF, "table load status");
        compare_stream("R8", "stream after table load");
        check("R6", mem[dw((d+1) % NDESC)], 32'h0, "frame after table status");
        cur_idx = (d + 2) % NDESC;
        for (int e = 0; e < 16; e++) probe(tbl_exp[e], 1'b1, "R9", "loaded entry matches");
        probe(tbl_exp[0] ^ 48'h8000_0000_0000, 1'b0, "R9", "top byte differs");
        probe(tbl_exp[7] ^ 48'h0000_0000_0001, 1'b0, "R9", "bottom byte differs");

        // R10 wrong table size and zero-length frame
        for (int w = 0; w < 48; w++) mem[(32'h900>>2) + w] = $urandom;
        bad_ent = {mem[(32'h900>>2)+2][15:0], mem[(32'h900>>2)+1][15:0], mem[(32'h900>>2)][15:0]};
        clear_streams();
        d = cur_idx;
        set_desc(d, 32'h8000_0000, ctl_word(100, 1'b0, 1'b1, d == NDESC-1), 32'h900);
        set_desc((d+1) % NDESC, 32'h8000_0000, ctl_word(0, 1'b1, 1'b0, ((d+1) % NDESC) == NDESC-1), 32'h400);
        wr_reg(2'd1, 32'd1);
        wait_quiet();
        check("R10", mem[dw(d)], 32'h0000_8000, "wrong table size status");
        check("R10", mem[dw((d+1) % NDESC)], 32'h0000_8000, "zero length status");
        check("R10", got_b.size(), 0, "bytes sent on faults");
        probe(tbl_exp[5], 1'b1, "R10", "old entry kept");
        probe(bad_ent, 1'b0, "R10", "rejected image not loaded");
        cur_idx = (d + 2) % NDESC;

        // R11 stalled MAC and slow memory
        ready_pct = 30;
        for (int r = 0; r < 5; r++) begin
            max_lat = 2;
            run_round($urandom_range(1, 3), "R11");
        end
        ready_pct = 100;

        // R2 stop, poll ignored, restart from base
        wr_reg(2'd2, 32'd0);
        for (int i = 0; i < NDESC; i++) set_desc(i, 32'd0, 32'd0, 32'd0);
        clear_streams();
        add_frame(0, 5, 1'b1);
        reads0 = n_reads;
        wr_reg(2'd1, 32'd1);
        repeat (30) @(negedge clk);
        check("R2", n_reads, reads0, "reads after poll while stopped again");
        check("R2", mem[dw(0)], 32'h8000_0000, "descriptor untouched while stopped");
        wr_reg(2'd2, 32'd1);
        wr_reg(2'd1, 32'd1);
        wait_quiet();
        compare_stream("R2", "restart from ring base");
        check("R2", mem[dw(0)], 32'h0, "restart descriptor completed");
        check("R2", last_sts_addr, RING + 16, "scan stops after base slot");

        summary();
        $finish;
    end
endmodule